// File: doc/BRIEF.md
# External Memory Bus Controller with Timeout Monitor

This block connects an internal request/acknowledge port to an external asynchronous memory bus. The bus has a 16-bit data path and a 22-bit byte address. The bus timing comes from the system clock through a selectable divider of 1, 2 or 4. Every output to the bus pins changes only on a bus-clock enable edge. Four chip-select regions decode the request address. Each region has its own base, mask, wait-state count and ending mode.

An access can end in one of two ways. In fixed-wait mode it ends after its programmed wait states. In handshake mode it ends when the device pulls the transfer-acknowledge input low. A monitor counts bus cycles during handshake accesses. It ends an access that stays silent too long, releases the chip select and returns an error.

A 32-bit internal access becomes two 16-bit bus cycles. The lower halfword address goes first, and the chip select stays released for one bus cycle between the two halves.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, all chip selects, `eb_rd_n` and `eb_we_n` are high, and `eb_oe`, `ack` and `err` are low.
- R2: The bus outputs change only on an enable edge. `div_sel` 0 gives an enable on every clock, 1 on every second clock, and 2 or 3 on every fourth clock. A chip select therefore stays low for a whole multiple of the divide ratio.
- R3: Region i matches when `(req_addr & mask_i) == (base_i & mask_i)`, and the lowest matching index wins. At most one chip select (active low, bit i for region i) is low at a time. A request that matches no region is answered with `ack` and `err` and drives no chip select.
- R4: In fixed-wait mode (`cs_hs[i]`=0), each 16-bit bus cycle keeps its chip select low for (`cs_wait[4i+3:4i]` + 1) bus cycles.
- R5: In handshake mode (`cs_hs[i]`=1), the bus cycle ends at the first enable edge that samples `eb_ta_n` low. Once that edge samples it low, the handshake wins even if the timeout is reached on the same edge.
- R6: In handshake mode with `mon_en`=1, the access ends with `err`=1 and all chip selects released on the `mon_limit`-th bus cycle after the first, if no acknowledge has arrived by then. With `mon_en`=0, the access waits for the acknowledge without limit.
- R7: When `req_wide`=1, the access runs two bus cycles. The first uses `req_addr` with data bits [15:0], and the second uses `req_addr`+2 with bits [31:16]. A narrow read returns the bus data zero-extended in `rdata`.
- R8: A read drives `eb_rd_n` low with `eb_oe` low. A write drives `eb_we_n` low with `eb_oe` high and the write half on `eb_dout`. The two strobes are never low together.
- R9: `ack` is a single-clock pulse for each request, and `err` is only high together with `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 2 | Bus clock divide select: 0 gives /1, 1 gives /2, 2 or 3 gives /4 |
| cs_base | input | NCS*AW | Base address for each region, region i at bits [AW*i +: AW] |
| cs_mask | input | NCS*AW | Compare mask for each region |
| cs_wait | input | NCS*4 | Wait-state count for each region, 0 to 15 |
| cs_hs | input | NCS | Handshake mode enable for each region |
| mon_en | input | 1 | Bus monitor enable |
| mon_limit | input | MW | Monitor limit in bus cycles (0 acts as 2^MW) |
| req | input | 1 | Request, held until ack |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | Completion pulse |
| err | output | 1 | Error flag, valid with ack |
| rdata | output | 32 | Read data, valid with ack |
| eb_addr | output | AW | External address |
| eb_dout | output | 16 | External write data |
| eb_oe | output | 1 | Data bus drive enable |
| eb_din | input | 16 | External read data |
| eb_cs_n | output | NCS | Active-low chip selects |
| eb_rd_n | output | 1 | Active-low read strobe |
| eb_we_n | output | 1 | Active-low write strobe |
| eb_ta_n | input | 1 | Active-low transfer acknowledge from the device |

## Verification
Any error in the wait or monitor counters shows up at the pins in the same access. The chip-select low time moves away from (wait+1) bus cycles, or from the monitor limit, and the bench measures that time exactly in system clocks. A wrong region index or a wrong halfword order appears on the first chip-select fall, or as swapped halves in `rdata` when `ack` arrives. A divider fault stretches or shrinks every measured low time by the ratio.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int AW  = 22,
  parameter int NCS = 4,
  parameter int MW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        div_sel,
  input  logic [NCS*AW-1:0] cs_base,
  input  logic [NCS*AW-1:0] cs_mask,
  input  logic [NCS*4-1:0]  cs_wait,
  input  logic [NCS-1:0]    cs_hs,
  input  logic              mon_en,
  input  logic [MW-1:0]     mon_limit,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_wide,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic              ack,
  output logic              err,
  output logic [31:0]       rdata,
  output logic [AW-1:0]     eb_addr,
  output logic [15:0]       eb_dout,
  output logic              eb_oe,
  input  logic [15:0]       eb_din,
  output logic [NCS-1:0]    eb_cs_n,
  output logic              eb_rd_n,
  output logic              eb_we_n,
  input  logic              eb_ta_n
);
  localparam int IW = $clog2(NCS > 1 ? NCS : 2);
  localparam logic [MW-1:0] MONE = 1;
  localparam logic [AW-1:0] HSTEP = 2;

  typedef enum logic [1:0] {IDLE, ACC, NEXT} st_t;
  st_t st;

  logic [1:0]    dcnt, dlim;
  logic          tick;
  logic          hit;
  logic [IW-1:0] hidx, rid, lid;
  logic          we_q, wide_q, hi_q;
  logic [31:0]   wd_q;
  logic [AW-1:0] a_q;
  logic [3:0]    wcnt, lwait;
  logic [MW-1:0] mcnt;
  logic [15:0]   lo_q;
  logic          hs_sel, done, tout;
  logic [NCS-1:0] lcs;

  // bus clock enable
  assign dlim = (div_sel == 2'd0) ? 2'd0 : (div_sel == 2'd1) ? 2'd1 : 2'd3;
  assign tick = (dcnt >= dlim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else        dcnt <= tick ? 2'd0 : dcnt + 2'd1;

  // region decode, lowest index wins
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = NCS - 1; i >= 0; i--)
      if ((req_addr & cs_mask[i*AW +: AW]) == (cs_base[i*AW +: AW] & cs_mask[i*AW +: AW])) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
  end

  assign lid    = (st == IDLE) ? hidx : rid;
  assign lwait  = cs_wait[int'(lid)*4 +: 4];
  assign lcs    = ~(NCS'(1) << lid);
  assign hs_sel = cs_hs[rid];
  assign done   = hs_sel ? !eb_ta_n : (wcnt == 4'd0);
  assign tout   = hs_sel && mon_en && ((mcnt + MONE) == mon_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      ack     <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
      eb_addr <= '0;
      eb_dout <= '0;
      eb_oe   <= 1'b0;
      eb_cs_n <= '1;
      eb_rd_n <= 1'b1;
      eb_we_n <= 1'b1;
      rid     <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      hi_q    <= 1'b0;
      wd_q    <= '0;
      a_q     <= '0;
      wcnt    <= '0;
      mcnt    <= '0;
      lo_q    <= '0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      if (tick) begin
        case (st)
          IDLE: if (req) begin
            if (!hit) begin
              ack <= 1'b1;
              err <= 1'b1;
            end else begin
              rid     <= hidx;
              we_q    <= req_we;
              wide_q  <= req_wide;
              wd_q    <= req_wdata;
              a_q     <= req_addr;
              hi_q    <= 1'b0;
              eb_cs_n <= lcs;
              eb_addr <= req_addr;
              eb_rd_n <= req_we;
              eb_we_n <= !req_we;
              eb_oe   <= req_we;
              eb_dout <= req_wdata[15:0];
              wcnt    <= lwait;
              mcnt    <= '0;
              st      <= ACC;
            end
          end
          NEXT: begin
            hi_q    <= 1'b1;
            eb_cs_n <= lcs;
            eb_addr <= a_q + HSTEP;
            eb_rd_n <= we_q;
            eb_we_n <= !we_q;
            eb_oe   <= we_q;
            eb_dout <= wd_q[31:16];
            wcnt    <= lwait;
            mcnt    <= '0;
            st      <= ACC;
          end
          ACC: begin
            if (done || tout) begin
              eb_cs_n <= '1;
              eb_rd_n <= 1'b1;
              eb_we_n <= 1'b1;
              eb_oe   <= 1'b0;
            end
            if (done) begin
              if (wide_q && !hi_q) begin
                lo_q <= eb_din;
                st   <= NEXT;
              end else begin
                if (!we_q) rdata <= wide_q ? {eb_din, lo_q} : {16'h0000, eb_din};
                ack <= 1'b1;
                st  <= IDLE;
              end
            end else if (tout) begin
              ack <= 1'b1;
              err <= 1'b1;
              st  <= IDLE;
            end else begin
              if (wcnt != 4'd0) wcnt <= wcnt - 4'd1;
              mcnt <= mcnt + MONE;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R2
  pins_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(eb_cs_n) && $stable(eb_addr) && $stable(eb_dout) &&
               $stable(eb_oe) && $stable(eb_rd_n) && $stable(eb_we_n)));
  // R3
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~eb_cs_n));
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!eb_rd_n && !eb_we_n));
  // R8
  drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n) eb_oe |-> !eb_we_n);
  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  // R9
  err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> ack);
  // R6
  err_release_chk: assert property (@(posedge clk) disable iff (!rst_n) (ack && err) |-> (&eb_cs_n));
endmodule

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
  localparam int AW = 22, NCS = 4, MW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [NCS*AW-1:0] cs_base, cs_mask;
  logic [NCS*4-1:0] cs_wait;
  logic [NCS-1:0] cs_hs;
  logic mon_en = 1'b0;
  logic [MW-1:0] mon_limit = 8'd10;
  logic req = 1'b0, req_we = 1'b0, req_wide = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic ack, err;
  logic [31:0] rdata;
  logic [AW-1:0] eb_addr;
  logic [15:0] eb_dout, eb_din;
  logic eb_oe, eb_rd_n, eb_we_n;
  logic [NCS-1:0] eb_cs_n;
  logic eb_ta_n = 1'b1;

  int nvec = 0, nbad = 0;
  int lowcyc = 0, cscnt = 0, ta_delay = 1000;
  logic [AW-1:0] a_first, a_last;
  logic [15:0] d_first, d_last;
  logic [NCS-1:0] cs_first;
  logic rd_first, we_first, oe_first;
  logic [31:0] r_got;
  logic e_got;

  always #5 clk = ~clk;

  assign eb_din = eb_addr[15:0] ^ 16'h5A00;

  ext_bus_ctrl #(.AW(AW), .NCS(NCS), .MW(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cs_base(cs_base), .cs_mask(cs_mask),
    .cs_wait(cs_wait), .cs_hs(cs_hs), .mon_en(mon_en), .mon_limit(mon_limit),
    .req(req), .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .err(err), .rdata(rdata), .eb_addr(eb_addr),
    .eb_dout(eb_dout), .eb_oe(eb_oe), .eb_din(eb_din), .eb_cs_n(eb_cs_n),
    .eb_rd_n(eb_rd_n), .eb_we_n(eb_we_n), .eb_ta_n(eb_ta_n));

  // bus observer and acknowledging device model
  always @(negedge clk) begin
    if (eb_cs_n != '1) begin
      if (lowcyc == 0) begin
        a_first = eb_addr; d_first = eb_dout; cs_first = eb_cs_n;
        rd_first = eb_rd_n; we_first = eb_we_n; oe_first = eb_oe;
      end
      a_last = eb_addr; d_last = eb_dout;
      lowcyc = lowcyc + 1;
      cscnt = cscnt + 1;
      eb_ta_n = (cscnt >= ta_delay) ? 1'b0 : 1'b1;
    end else begin
      cscnt = 0;
      eb_ta_n = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic wide, input logic [AW-1:0] a, input logic [31:0] wd);
    int guard;
    @(negedge clk);
    lowcyc = 0;
    req = 1'b1; req_we = we; req_wide = wide; req_addr = a; req_wdata = wd;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!ack && guard < 2000);
    chk("R9 ack arrives", {31'd0, ack}, 32'd1);
    r_got = rdata; e_got = err;
    req = 1'b0;
    @(negedge clk);
    chk("R9 ack single pulse", {31'd0, ack}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 cs idle", {28'd0, eb_cs_n}, 32'hF);
    chk("R1 strobes idle", {29'd0, eb_rd_n, eb_we_n, eb_oe}, 32'h6);
    chk("R1 ack err low", {30'd0, ack, err}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", {27'd0, eb_cs_n, eb_oe}, 32'h1E);
  endtask

  task automatic t_read16_div4;
    div_sel = 2'd2;
    xfer(1'b0, 1'b0, 22'h020010, 32'h0);
    chk("R2 R4 cs low at /4 wait 5", lowcyc, 24);
    chk("R7 narrow read zero-extended", r_got, 32'h00005A10);
    chk("R8 read strobes", {29'd0, rd_first, we_first, oe_first}, 32'h2);
    chk("R9 no err", {31'd0, e_got}, 32'd0);
  endtask

  task automatic t_read32_div2;
    div_sel = 2'd1;
    xfer(1'b0, 1'b1, 22'h000100, 32'h0);
    chk("R2 R4 cs low at /2 two halves wait 2", lowcyc, 12);
    chk("R7 first address", {10'd0, a_first}, 32'h100);
    chk("R7 second address", {10'd0, a_last}, 32'h102);
    chk("R7 halves order", r_got, 32'h5B025B00);
  endtask

  task automatic t_write32;
    div_sel = 2'd0;
    xfer(1'b1, 1'b1, 22'h000200, 32'hDEADBEEF);
    chk("R4 cs low at /1 wait 2 two halves", lowcyc, 6);
    chk("R7 low half written first", {16'd0, d_first}, 32'hBEEF);
    chk("R7 high half second", {16'd0, d_last}, 32'hDEAD);
    chk("R8 write strobes", {29'd0, rd_first, we_first, oe_first}, 32'h5);
  endtask

  task automatic t_priority;
    div_sel = 2'd0;
    xfer(1'b0, 1'b0, 22'h030004, 32'h0);
    chk("R3 lowest region wins", {28'd0, cs_first}, 32'hB);
    chk("R4 region 2 wait 5", lowcyc, 6);
  endtask

  task automatic t_unmatched;
    xfer(1'b0, 1'b0, 22'h100000, 32'h0);
    chk("R3 unmatched err", {31'd0, e_got}, 32'd1);
    chk("R3 unmatched no cs", lowcyc, 0);
  endtask

  task automatic t_handshake;
    div_sel = 2'd0; mon_en = 1'b1; mon_limit = 8'd20; ta_delay = 3;
    xfer(1'b0, 1'b0, 22'h010040, 32'h0);
    chk("R5 ends on ta", lowcyc, 3);
    chk("R5 no err", {31'd0, e_got}, 32'd0);
    chk("R5 read data", r_got, 32'h00005A40);
  endtask

  task automatic t_timeout;
    mon_en = 1'b1; mon_limit = 8'd5; ta_delay = 1000;
    xfer(1'b1, 1'b0, 22'h010002, 32'h1234);
    chk("R6 timeout err", {31'd0, e_got}, 32'd1);
    chk("R6 timeout length", lowcyc, 5);
    chk("R6 cs released", {28'd0, eb_cs_n}, 32'hF);
  endtask

  task automatic t_monoff;
    mon_en = 1'b0; mon_limit = 8'd5; ta_delay = 30;
    xfer(1'b0, 1'b0, 22'h010006, 32'h0);
    chk("R6 monitor off waits", lowcyc, 30);
    chk("R6 monitor off no err", {31'd0, e_got}, 32'd0);
    ta_delay = 1000;
  endtask

  initial begin
    cs_base = {22'h030000, 22'h020000, 22'h010000, 22'h000000};
    cs_mask = {22'h3F0000, 22'h3E0000, 22'h3F0000, 22'h3F0000};
    cs_wait = {4'd1, 4'd5, 4'd0, 4'd2};
    cs_hs   = 4'b0010;
    t_reset();
    t_read16_div4();
    t_read32_div2();
    t_write32();
    t_priority();
    t_unmatched();
    t_handshake();
    t_timeout();
    t_monoff();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #2000000;
    nvec++; nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule